// File: doc/BRIEF.md
# Temperature conversion scheduler

This block decides when a temperature ADC begins a conversion. In auto mode a rate timer paces the conversions: a new one starts each time a programmable period has elapsed and the ADC is idle. In standby mode nothing starts by itself. In either mode a one-shot command starts a conversion at once. A one-shot given in auto mode also restarts the rate timer, so the next paced conversion comes a full period later. A one-shot given in standby runs a single conversion, and the block then stays in standby.

The ADC receives a start pulse and an abort pulse, and it answers with a done pulse. A conversion is cut short in three cases: when standby is entered while the conversion runs, when a one-shot arrives during it, and when it exceeds a fixed maximum duration (150 ms by default, converted to clock cycles). The busy output reports a running conversion.

Top module: `conv_sched`

## Requirements
- R1: After reset, busy_o, conv_start_o and conv_abort_o are low, the block is in auto mode and the rate timer is zero. With standby_i low, the first conversion_start pulse comes P clock edges after reset is released, where P is rate_period_i.
- R2: While standby_i is low (auto mode), the rate timer counts every cycle. When it reaches P and no conversion is running, conv_start_o pulses one cycle after that edge. The timer then restarts from zero. If a conversion is still running when the period ends, the start waits until busy_o falls.
- R3: A one-shot pulse (oneshot_i high for one cycle) makes conv_start_o and busy_o high in the following cycle, in either mode.
- R4: While standby_i is high, the only thing that can start a conversion is a one-shot, and each one-shot starts exactly one conversion.
- R5: A one-shot in auto mode sets the rate timer to zero. The next automatic start comes no earlier than P edges after the start caused by the one-shot.
- R6: busy_o is high from the cycle in which conv_start_o pulses until the edge after conv_done_i arrives. conv_done_i clears busy_o without an abort pulse.
- R7: A rising edge of standby_i during a conversion, with no one-shot in the same cycle, gives one conv_abort_o pulse and drops busy_o in the next cycle.
- R8: A one-shot during a running conversion gives conv_abort_o and conv_start_o in the same cycle, and busy_o stays high.
- R9: A conversion that receives no conv_done_i is aborted after TIMEOUT_CYC cycles of busy: conv_abort_o pulses and busy_o falls.
- R10: conv_done_i has no effect while busy_o is low. A one-shot in the same cycle as conv_done_i takes priority and restarts the conversion.
- R11: A rate_period_i of zero acts as a period of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | High selects standby, low selects auto mode |
| oneshot_i | input | 1 | One-cycle one-shot command |
| rate_period_i | input | RATE_W | Rate timer period in cycles |
| conv_done_i | input | 1 | One-cycle pulse from the ADC at the end of a conversion |
| conv_start_o | output | 1 | One-cycle pulse that starts a conversion |
| conv_abort_o | output | 1 | One-cycle pulse that cancels the running conversion |
| busy_o | output | 1 | High while a conversion is running |

## Verification
The bench builds the block with RATE_W = 6 and TIMEOUT_CYC = 30, and it drives periods from 0 to 20 cycles. With these values the timeout, a zero period, and a period that ends while a conversion is still running all occur within a few dozen cycles. An ADC model in the bench sometimes never answers, and this exercises the timeout abort. Standby edges, one-shots during conversions and stray done pulses fall on every phase of the rate timer.

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int RATE_W      = 16,
  parameter int CLK_HZ      = 100_000_000,
  parameter int TIMEOUT_MS  = 150,
  parameter int TIMEOUT_CYC = CLK_HZ / 1000 * TIMEOUT_MS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              oneshot_i,
  input  logic [RATE_W-1:0] rate_period_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic              conv_abort_o,
  output logic              busy_o
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {EV_NONE, EV_SHOT, EV_STOP, EV_DONE, EV_TMO, EV_AUTO} ev_t;

  logic [RATE_W-1:0] rate_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              busy_q, sb_q, start_q, abort_q;
  ev_t               ev;

  wire [RATE_W:0] rate_inc = {1'b0, rate_q} + (RATE_W+1)'(1);
  wire rate_due = rate_inc >= {1'b0, rate_period_i};
  wire stop_req = standby_i & ~sb_q & busy_q;
  wire tmo_hit  = busy_q & (tmo_q == TMO_LAST);
  wire auto_go  = ~busy_q & ~standby_i & rate_due;
  wire starting = (ev == EV_SHOT) | (ev == EV_AUTO);

  always_comb begin
    if (oneshot_i)                ev = EV_SHOT;
    else if (stop_req)            ev = EV_STOP;
    else if (busy_q & conv_done_i) ev = EV_DONE;
    else if (tmo_hit)             ev = EV_TMO;
    else if (auto_go)             ev = EV_AUTO;
    else                          ev = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= '0;
      tmo_q   <= '0;
      busy_q  <= 1'b0;
      sb_q    <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      sb_q    <= standby_i;
      start_q <= starting;
      abort_q <= (ev == EV_STOP) | (ev == EV_TMO) | ((ev == EV_SHOT) & busy_q);

      case (ev)
        EV_SHOT, EV_AUTO:        busy_q <= 1'b1;
        EV_STOP, EV_DONE, EV_TMO: busy_q <= 1'b0;
        default:                 busy_q <= busy_q;
      endcase

      if (starting)
        tmo_q <= '0;
      else if (busy_q & (ev == EV_NONE))
        tmo_q <= tmo_q + TMO_W'(1);

      if (standby_i | starting)
        rate_q <= '0;
      else if (!rate_due)
        rate_q <= rate_inc[RATE_W-1:0];
    end
  end

  assign conv_start_o = start_q;
  assign conv_abort_o = abort_q;
  assign busy_o       = busy_q;
endmodule

module conv_sched_chk #(
  parameter int TIMEOUT_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic standby_i,
  input logic oneshot_i,
  input logic conv_done_i,
  input logic conv_start_o,
  input logic conv_abort_o,
  input logic busy_o
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)            run_len <= 0;
    else if (!busy_o)      run_len <= 0;
    else if (conv_start_o) run_len <= 1;
    else                   run_len <= run_len + 1;
  end

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> busy_o);
  assert_shot_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_i |=> (conv_start_o && busy_o));
  assert_shot_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_i && busy_o) |=> conv_abort_o);
  assert_stop_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(standby_i) && busy_o && !oneshot_i) |=> (conv_abort_o && !busy_o));
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && conv_done_i && !oneshot_i && !$rose(standby_i)) |=> (!busy_o && !conv_abort_o));
  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i && !oneshot_i) |=> !conv_start_o);
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && conv_done_i && standby_i && !oneshot_i) |=> !busy_o);
  assert_abort_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> $past(busy_o));
  assert_run_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_len <= TIMEOUT_CYC));
endmodule

bind conv_sched conv_sched_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .oneshot_i(oneshot_i),
  .conv_done_i(conv_done_i), .conv_start_o(conv_start_o),
  .conv_abort_o(conv_abort_o), .busy_o(busy_o)
);

// File: tb/conv_sched_test.sv
module conv_sched_test;
  localparam int RW   = 6;
  localparam int TMO  = 30;
  localparam int NCYC = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 1'b0, oneshot = 1'b0, done = 1'b0;
  logic [RW-1:0] period = RW'(5);
  logic start_o, abort_o, busy_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  conv_sched #(.RATE_W(RW), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .oneshot_i(oneshot),
    .rate_period_i(period), .conv_done_i(done),
    .conv_start_o(start_o), .conv_abort_o(abort_o), .busy_o(busy_o));

  // reference state
  bit m_busy, m_start, m_abort, m_sbq, m_first, m_after_os;
  int m_cnt, m_tcnt;
  string m_tag;

  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic model_step(input bit os, input bit sb, input bit dn, input int per);
    bit ob = m_busy;
    bit stop = sb && !m_sbq && ob;
    bit due = (m_cnt + 1) >= eff_period(per);
    bit st = 0;
    m_start = 0; m_abort = 0; m_tag = "R6";
    if (os) begin
      st = 1; m_abort = ob; m_busy = 1; m_after_os = !sb;
      m_tag = ob ? "R8" : (sb ? "R4" : "R3");
      if (dn) m_tag = "R10";
    end else if (stop) begin
      m_abort = 1; m_busy = 0; m_tag = "R7";
    end else if (ob && dn) begin
      m_busy = 0; m_tag = "R6";
    end else if (ob && m_tcnt == TMO - 1) begin
      m_abort = 1; m_busy = 0; m_tag = "R9";
    end else if (!ob && !sb && due) begin
      st = 1; m_busy = 1;
      m_tag = m_first ? "R1" : (m_after_os ? "R5" : (per == 0 ? "R11" : "R2"));
      m_first = 0; m_after_os = 0;
    end else if (dn) begin
      m_tag = "R10";
    end
    m_start = st;
    if (st) m_tcnt = 0;
    else if (ob && m_busy) m_tcnt++;
    if (sb || st) m_cnt = 0;
    else if (!due) m_cnt++;
    m_sbq = sb;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp, input int cyc);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  initial begin
    int adc_left = 0;
    bit hang = 0;
    void'($urandom(32'd2718));
    m_busy = 0; m_start = 0; m_abort = 0; m_sbq = 0; m_first = 1; m_after_os = 0;
    m_cnt = 0; m_tcnt = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", busy_o, 1'b0, -1);
    chk("R1", "start after reset", start_o, 1'b0, -1);
    chk("R1", "abort after reset", abort_o, 1'b0, -1);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit os = 0, sb = standby, dn = 0;
      int per = int'(period);
      if (adc_left > 0) begin
        dn = (adc_left == 1);
        adc_left--;
      end
      if (cyc < 200) begin
        if (cyc == 40 || cyc == 60 || cyc == 63 || cyc == 110 || cyc == 130) os = 1;
        if (cyc == 80) per = 0;
        if (cyc == 100) sb = 1;
        if (cyc == 120) dn = 1;
        if (cyc == 185) begin sb = 0; per = 7; end
      end else begin
        if ($urandom % 30 == 0) os = 1;
        if ($urandom % 200 == 0) sb = !sb;
        if ($urandom % 60 == 0) dn = 1;
        if ($urandom % 300 == 0) begin
          case ($urandom % 5)
            0: per = 0; 1: per = 1; 2: per = 3; 3: per = 8; default: per = 20;
          endcase
        end
      end
      oneshot = os; standby = sb; done = dn; period = RW'(per);
      model_step(os, sb, dn, per);
      @(negedge clk);
      chk(m_tag, "conv_start_o", start_o, m_start, cyc);
      chk(m_tag, "conv_abort_o", abort_o, m_abort, cyc);
      chk(m_tag, "busy_o", busy_o, m_busy, cyc);
      if (abort_o) begin adc_left = 0; hang = 0; end
      if (start_o) begin
        if (cyc < 55) hang = 0;
        else if (cyc < 100) begin hang = 0; adc_left = 10; end
        else if (cyc < 125) begin hang = 0; adc_left = 3; end
        else if (cyc < 185) begin hang = 1; adc_left = 0; end
        else if ($urandom % 15 == 0) begin hang = 1; adc_left = 0; end
        else begin hang = 0; adc_left = 1 + int'($urandom % 12); end
        if (cyc < 55) adc_left = 2;
      end
    end
    oneshot = 0; done = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule